// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small microcontroller between normal running and three graded stop states. When the core signals wait-for-interrupt, the sequencer reads a mode selector and enters light sleep, power-down or deep power-down. Each state gates a larger set of resources. Light sleep stops only the core clock. Power-down stops every digital clock and trims analog blocks and oscillators to a configured set. Deep power-down removes power from the main domain and leaves only a retained register bank alive.

Oscillators, the PLL and the power switch lie outside the block. It sees each of them as an enable output paired with a ready, lock or power-good input. When the chip leaves power-down, the sequencer turns the chosen clock source back on and waits for it to report ready. It then waits a settle interval that depends on the source, opens the clock gates, and only after that acknowledges the wake to the core. When the chip leaves deep power-down, the sequencer restores power, waits for power-good, and holds the main domain in reset for a fixed number of cycles. A retained flag records that deep power-down came before that reset.

Top module: `pmu_mode_seq`

## Requirements
- R1: After `rst_n` is released, the block is in run (`mode_o`=0). `core_clk_en`=1, `periph_clk_en` equals `periph_en`, `main_pwr_on`=1, `main_rst_n`=1, and `wake_ack`=0 and `dpd_flag`=0.
- R2: In run, `src_en` follows `clk_src` at once. The mapping is 0→0001 (low-power oscillator), 1→0010 (RC oscillator), 2→0100 (crystal) and 3→1100 (crystal plus PLL).
- R3: A `wfi_req` pulse in run with `mode_sel` equal to 00 or 11 enters sleep (`mode_o`=1) at the next edge. In sleep, `core_clk_en`=0, `periph_clk_en` equals `periph_en`, and `ana_en` is all ones.
- R4: In sleep, `irq` or `wake_pin` returns the block to run at the next edge, with `core_clk_en`=1 and `wake_ack` high for exactly one cycle. Without either input, the block stays in sleep.
- R5: A `wfi_req` pulse with `mode_sel`=01 enters power-down (`mode_o`=2). There, the core and peripheral clocks are 0 and `ana_en` equals `pd_keep`. `src_en` is the R2 mask when `pd_osc_keep`=1 and 0000 otherwise.
- R6: In power-down, `irq` or `wake_pin` re-enables the selected source. The sequencer then waits until every bit of that source's R2 mask is high in `src_rdy` (bit 2 crystal ready, bit 3 PLL lock). After the settle count it raises the clock enables, and `wake_ack` follows one cycle later.
- R7: When `src_rdy` is already high, `wake_ack` first rises L+2 edges after the edge that samples the wake. L is 0, 3, 10 and 20 for `clk_src` 0, 1, 2 and 3.
- R8: In deep power-down (`mode_sel`=10), `main_pwr_on`=0, `main_rst_n`=0 and all clock, analog and source enables are 0. `irq` has no effect on any of them.
- R9: A `wake_pin` pulse in deep power-down turns main power on while the reset stays low. Once `pwr_good` is sampled high, `main_rst_n` stays low for 4 cycles and then releases with the block in run and `wake_ack` low.
- R10: `dpd_flag` sets on entry to deep power-down and stays set through the wake. Only a `dpd_flag_clr` pulse clears it, and only while main power is up and out of reset.
- R11: The retained bank keeps written words through deep power-down. Writes made while main power is off or the main domain is in reset are ignored.
- R12: A `wfi_req` that arrives while a wake is in progress is held. It takes effect with the `mode_sel` of the first run cycle, one edge after that run cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, clears everything |
| wfi_req | input | 1 | Wait-for-interrupt pulse from the core |
| mode_sel | input | 2 | Stop mode: 00/11 sleep, 01 power-down, 10 deep power-down |
| clk_src | input | 2 | System and wake clock source select |
| periph_en | input | NPERIPH | Per-peripheral clock enables |
| pd_keep | input | NANA | Analog blocks left on in power-down |
| pd_osc_keep | input | 1 | Leave the selected source running in power-down |
| irq | input | 1 | Any qualifying interrupt |
| wake_pin | input | 1 | Dedicated wake input |
| src_rdy | input | 4 | Source ready and PLL lock |
| pwr_good | input | 1 | Main domain supply is stable |
| aon_we | input | 1 | Retained bank write strobe |
| aon_addr | input | AON_AW | Retained bank address |
| aon_wdata | input | AON_DW | Retained bank write data |
| dpd_flag_clr | input | 1 | Clear the deep power-down flag |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | NPERIPH | Peripheral clock gate enables |
| ana_en | output | NANA | Analog block enables |
| src_en | output | 4 | Clock source enables |
| main_pwr_on | output | 1 | Main power switch control |
| main_rst_n | output | 1 | Main domain reset, active low |
| wake_ack | output | 1 | One-cycle wake acknowledge to the core |
| mode_o | output | 2 | 0 run, 1 sleep, 2 power-down, 3 deep power-down (transitions report the state being left) |
| dpd_flag | output | 1 | Deep power-down preceded the last main reset |
| aon_rdata | output | AON_DW | Retained bank read data |

## Verification
A wrong sequencer state appears at the ports on the next edge. It shows up as a clock enable set in the wrong stop mode, or as `wake_ack` coming too early, too late or twice. A wrong settle count or a missed ready bit shifts the `wake_ack` cycle, which the bench measures exactly for each source. Trouble in the retained domain stays hidden until a deep power-down wake, after which the flag and the bank read-back reveal it.

// File: rtl/pmu_pkg.sv
// Shared types and helpers for the low-power mode sequencer.
// Assumes four clock sources with the PLL stacked on the crystal.
package pmu_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_PD,
        ST_PD_WAKE,
        ST_PD_UNGATE,
        ST_DPD,
        ST_DPD_PWRUP,
        ST_DPD_RST
    } pmu_state_e;

    localparam logic [1:0] SEL_PD  = 2'b01;
    localparam logic [1:0] SEL_DPD = 2'b10;

    localparam logic [1:0] MODE_RUN   = 2'd0;
    localparam logic [1:0] MODE_SLEEP = 2'd1;
    localparam logic [1:0] MODE_PD    = 2'd2;
    localparam logic [1:0] MODE_DPD   = 2'd3;

    // Source enable mask for a source selection
    function automatic logic [3:0] src_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0010;
            2'd2:    return 4'b0100;
            default: return 4'b1100;
        endcase
    endfunction

    // Visible mode reported for each internal state
    function automatic logic [1:0] state_mode(input pmu_state_e s);
        case (s)
            ST_SLEEP:                            return MODE_SLEEP;
            ST_PD, ST_PD_WAKE, ST_PD_UNGATE:     return MODE_PD;
            ST_DPD, ST_DPD_PWRUP, ST_DPD_RST:    return MODE_DPD;
            default:                             return MODE_RUN;
        endcase
    endfunction

endpackage

// File: rtl/pmu_src_wait.sv
// Clock source wake wait: once active, waits until every ready bit of the
// selected source is high, then counts that source's settle cycles.
// Assumes ready bits are synchronous to clk. A ready drop restarts the count.
module pmu_src_wait #(
    parameter int LPO_SETTLE = 0,
    parameter int IRC_SETTLE = 3,
    parameter int XO_SETTLE  = 10,
    parameter int PLL_SETTLE = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] sel,
    input  logic [3:0] src_rdy,
    output logic       done
);
    import pmu_pkg::*;

    localparam int MAX_A  = (LPO_SETTLE > IRC_SETTLE) ? LPO_SETTLE : IRC_SETTLE;
    localparam int MAX_B  = (XO_SETTLE > PLL_SETTLE) ? XO_SETTLE : PLL_SETTLE;
    localparam int MAX_S  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = (MAX_S > 0) ? $clog2(MAX_S + 1) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] settle;
    logic          rdy_ok;

    // Pick the settle length for the selected source
    always_comb begin
        case (sel)
            2'd0:    settle = CW'(LPO_SETTLE);
            2'd1:    settle = CW'(IRC_SETTLE);
            2'd2:    settle = CW'(XO_SETTLE);
            default: settle = CW'(PLL_SETTLE);
        endcase
    end

    assign rdy_ok = &(src_rdy | ~src_mask(sel));
    assign done   = active && rdy_ok && (cnt >= settle);

    // Count settle cycles while the source reports ready
    always_ff @(posedge clk) begin
        if (!rst_n || !active || !rdy_ok) begin
            cnt <= '0;
        end else if (cnt < settle) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pmu_seq_ctl.sv
// Mode sequencer state machine: enters the selected stop state on a wait
// request, runs the wake handshakes and holds requests made mid-transition.
// Assumes wfi_req is a single-cycle pulse from the core.
module pmu_seq_ctl #(
    parameter int RST_HOLD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wfi_req,
    input  logic [1:0]          mode_sel,
    input  logic                irq,
    input  logic                wake_pin,
    input  logic                pwr_good,
    input  logic                src_done,
    output pmu_pkg::pmu_state_e state,
    output logic                wake_ack,
    output logic                dpd_enter
);
    import pmu_pkg::*;

    localparam int RW = (RST_HOLD > 1) ? $clog2(RST_HOLD + 1) : 1;
    localparam logic [RW-1:0] R_LAST = RW'(RST_HOLD - 1);

    pmu_state_e    nxt;
    logic          pend, pend_nxt, ack_nxt, go;
    logic [RW-1:0] rcnt;

    assign go = wfi_req || pend;

    // Next-state and acknowledge decision
    always_comb begin
        nxt     = state;
        ack_nxt = 1'b0;
        case (state)
            ST_RUN: if (go) begin
                case (mode_sel)
                    SEL_PD:  nxt = ST_PD;
                    SEL_DPD: nxt = ST_DPD;
                    default: nxt = ST_SLEEP;
                endcase
            end
            ST_SLEEP: if (irq || wake_pin) begin
                nxt     = ST_RUN;
                ack_nxt = 1'b1;
            end
            ST_PD:        if (irq || wake_pin) nxt = ST_PD_WAKE;
            ST_PD_WAKE:   if (src_done) nxt = ST_PD_UNGATE;
            ST_PD_UNGATE: begin
                nxt     = ST_RUN;
                ack_nxt = 1'b1;
            end
            ST_DPD:       if (wake_pin) nxt = ST_DPD_PWRUP;
            ST_DPD_PWRUP: if (pwr_good) nxt = ST_DPD_RST;
            ST_DPD_RST:   if (rcnt == R_LAST) nxt = ST_RUN;
            default:      nxt = ST_RUN;
        endcase
    end

    // Pending request: consumed in run, dropped while main domain is off
    always_comb begin
        case (state)
            ST_RUN, ST_DPD, ST_DPD_PWRUP, ST_DPD_RST: pend_nxt = 1'b0;
            default:                                  pend_nxt = pend || wfi_req;
        endcase
    end

    assign dpd_enter = (state == ST_RUN) && (nxt == ST_DPD);

    // State, pending latch, acknowledge and reset-hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            pend     <= 1'b0;
            wake_ack <= 1'b0;
            rcnt     <= '0;
        end else begin
            state    <= nxt;
            pend     <= pend_nxt;
            wake_ack <= ack_nxt;
            rcnt     <= (state == ST_DPD_RST) ? rcnt + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/pmu_gate_ctl.sv
// Gate and enable decode: maps the sequencer state to clock gates, analog
// enables, source enables, power switch and main reset.
// Assumes all outputs are registered or retimed downstream as needed.
module pmu_gate_ctl #(
    parameter int NPERIPH = 4,
    parameter int NANA    = 3
) (
    input  pmu_pkg::pmu_state_e state,
    input  logic [1:0]          clk_src,
    input  logic [NPERIPH-1:0]  periph_en,
    input  logic [NANA-1:0]     pd_keep,
    input  logic                pd_osc_keep,
    output logic                core_clk_en,
    output logic [NPERIPH-1:0]  periph_clk_en,
    output logic [NANA-1:0]     ana_en,
    output logic [3:0]          src_en,
    output logic                main_pwr_on,
    output logic                main_rst_n
);
    import pmu_pkg::*;

    logic [3:0] mask;
    assign mask = src_mask(clk_src);

    // Per-state decode of every controlled resource
    always_comb begin
        core_clk_en   = 1'b0;
        periph_clk_en = '0;
        ana_en        = '1;
        src_en        = mask;
        main_pwr_on   = 1'b1;
        main_rst_n    = 1'b1;
        case (state)
            ST_RUN, ST_PD_UNGATE: begin
                core_clk_en   = 1'b1;
                periph_clk_en = periph_en;
            end
            ST_SLEEP: periph_clk_en = periph_en;
            ST_PD: begin
                ana_en = pd_keep;
                src_en = pd_osc_keep ? mask : 4'b0000;
            end
            ST_PD_WAKE: ;
            ST_DPD: begin
                ana_en      = '0;
                src_en      = 4'b0000;
                main_pwr_on = 1'b0;
                main_rst_n  = 1'b0;
            end
            ST_DPD_PWRUP: begin
                ana_en     = '0;
                src_en     = 4'b0000;
                main_rst_n = 1'b0;
            end
            ST_DPD_RST: main_rst_n = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/pmu_aon_bank.sv
// Always-on retained registers plus the deep power-down flag. Cleared only
// by the power-on reset. Writes are accepted only while the main domain is
// powered and out of reset.
module pmu_aon_bank #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          flag_set,
    input  logic          flag_clr,
    output logic [DW-1:0] rdata,
    output logic          flag
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One retained word, written only while the main domain is alive
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_ok && we && (addr == AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = (int'(addr) < NREG) ? regs[addr] : '0;

    // Deep power-down flag: set on entry, cleared by a live main domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (flag_set) begin
            flag <= 1'b1;
        end else if (flag_clr && wr_ok) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pmu_mode_seq.sv
// Low-power mode sequencer top: wires the state machine, source wait,
// gate decode and retained bank together. Runs on an always-on clock.
// Assumes all inputs are synchronous to clk.
module pmu_mode_seq #(
    parameter int NPERIPH    = 4,
    parameter int NANA       = 3,
    parameter int AON_REGS   = 4,
    parameter int AON_DW     = 8,
    parameter int LPO_SETTLE = 0,
    parameter int IRC_SETTLE = 3,
    parameter int XO_SETTLE  = 10,
    parameter int PLL_SETTLE = 20,
    parameter int RST_HOLD   = 4,
    localparam int AON_AW    = (AON_REGS > 1) ? $clog2(AON_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wfi_req,
    input  logic [1:0]         mode_sel,
    input  logic [1:0]         clk_src,
    input  logic [NPERIPH-1:0] periph_en,
    input  logic [NANA-1:0]    pd_keep,
    input  logic               pd_osc_keep,
    input  logic               irq,
    input  logic               wake_pin,
    input  logic [3:0]         src_rdy,
    input  logic               pwr_good,
    input  logic               aon_we,
    input  logic [AON_AW-1:0]  aon_addr,
    input  logic [AON_DW-1:0]  aon_wdata,
    input  logic               dpd_flag_clr,
    output logic               core_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic [NANA-1:0]    ana_en,
    output logic [3:0]         src_en,
    output logic               main_pwr_on,
    output logic               main_rst_n,
    output logic               wake_ack,
    output logic [1:0]         mode_o,
    output logic               dpd_flag,
    output logic [AON_DW-1:0]  aon_rdata
);
    import pmu_pkg::*;

    pmu_state_e state;
    logic       src_done, dpd_enter;

    pmu_seq_ctl #(.RST_HOLD(RST_HOLD)) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi_req   (wfi_req),
        .mode_sel  (mode_sel),
        .irq       (irq),
        .wake_pin  (wake_pin),
        .pwr_good  (pwr_good),
        .src_done  (src_done),
        .state     (state),
        .wake_ack  (wake_ack),
        .dpd_enter (dpd_enter)
    );

    pmu_src_wait #(
        .LPO_SETTLE (LPO_SETTLE),
        .IRC_SETTLE (IRC_SETTLE),
        .XO_SETTLE  (XO_SETTLE),
        .PLL_SETTLE (PLL_SETTLE)
    ) i_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_PD_WAKE),
        .sel     (clk_src),
        .src_rdy (src_rdy),
        .done    (src_done)
    );

    pmu_gate_ctl #(.NPERIPH(NPERIPH), .NANA(NANA)) i_gate (
        .state         (state),
        .clk_src       (clk_src),
        .periph_en     (periph_en),
        .pd_keep       (pd_keep),
        .pd_osc_keep   (pd_osc_keep),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .ana_en        (ana_en),
        .src_en        (src_en),
        .main_pwr_on   (main_pwr_on),
        .main_rst_n    (main_rst_n)
    );

    pmu_aon_bank #(.NREG(AON_REGS), .DW(AON_DW), .AW(AON_AW)) i_aon (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (main_pwr_on && main_rst_n),
        .we       (aon_we),
        .addr     (aon_addr),
        .wdata    (aon_wdata),
        .flag_set (dpd_enter),
        .flag_clr (dpd_flag_clr),
        .rdata    (aon_rdata),
        .flag     (dpd_flag)
    );

    assign mode_o = state_mode(state);

endmodule

// File: rtl/pmu_mode_seq_chk.sv
// Port-level checker for the mode sequencer, attached by bind.
module pmu_mode_seq_chk #(
    parameter int NPERIPH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic               wake_pin,
    input logic [1:0]         mode_o,
    input logic               core_clk_en,
    input logic [NPERIPH-1:0] periph_clk_en,
    input logic               main_pwr_on,
    input logic               main_rst_n,
    input logic               wake_ack,
    input logic               dpd_flag
);
    // R4
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && (irq || wake_pin)) |=> (mode_o == 2'd0 && wake_ack));

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |=> !wake_ack);

    // R5
    pd_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && !core_clk_en) |-> (periph_clk_en == '0));

    // R6
    pd_ungate_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && core_clk_en) |=> (mode_o == 2'd0 && wake_ack));

    // R8
    dpd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr_on |-> (!main_rst_n && !core_clk_en && periph_clk_en == '0));

    // R8
    dpd_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pwr_on && !wake_pin) |=> !main_pwr_on);

    // R10
    dpd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> dpd_flag);

endmodule

bind pmu_mode_seq pmu_mode_seq_chk #(.NPERIPH(NPERIPH)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq           (irq),
    .wake_pin      (wake_pin),
    .mode_o        (mode_o),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .main_pwr_on   (main_pwr_on),
    .main_rst_n    (main_rst_n),
    .wake_ack      (wake_ack),
    .dpd_flag      (dpd_flag)
);

// File: tb/test_pmu_mode_seq.sv
`timescale 1ns/1ps
module test_pmu_mode_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wfi_req, pd_osc_keep, irq, wake_pin, pwr_good;
    logic       aon_we, dpd_flag_clr;
    logic [1:0] mode_sel, clk_src, aon_addr;
    logic [3:0] periph_en, src_rdy;
    logic [2:0] pd_keep;
    logic [7:0] aon_wdata;
    logic       core_clk_en, main_pwr_on, main_rst_n, wake_ack, dpd_flag;
    logic [3:0] periph_clk_en, src_en;
    logic [2:0] ana_en;
    logic [1:0] mode_o;
    logic [7:0] aon_rdata;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pmu_mode_seq i_pmu_mode_seq (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .mode_sel(mode_sel),
        .clk_src(clk_src), .periph_en(periph_en), .pd_keep(pd_keep),
        .pd_osc_keep(pd_osc_keep), .irq(irq), .wake_pin(wake_pin),
        .src_rdy(src_rdy), .pwr_good(pwr_good), .aon_we(aon_we),
        .aon_addr(aon_addr), .aon_wdata(aon_wdata), .dpd_flag_clr(dpd_flag_clr),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .ana_en(ana_en),
        .src_en(src_en), .main_pwr_on(main_pwr_on), .main_rst_n(main_rst_n),
        .wake_ack(wake_ack), .mode_o(mode_o), .dpd_flag(dpd_flag),
        .aon_rdata(aon_rdata)
    );

    function automatic logic [3:0] exp_mask(input int s);
        case (s)
            0: return 4'b0001;
            1: return 4'b0010;
            2: return 4'b0100;
            default: return 4'b1100;
        endcase
    endfunction

    function automatic int exp_settle(input int s);
        case (s)
            0: return 0;
            1: return 3;
            2: return 10;
            default: return 20;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_wfi(input logic [1:0] m);
        mode_sel = m;
        wfi_req  = 1'b1;
        step();
        wfi_req  = 1'b0;
    endtask

    task automatic aon_write(input logic [1:0] a, input logic [7:0] d);
        aon_addr = a; aon_wdata = d; aon_we = 1'b1;
        step();
        aon_we = 1'b0;
    endtask

    // Wake from power-down by irq; count edges until wake_ack
    task automatic pd_wake_measure(input int s);
        int  k = 0;
        logic prev_core = 1'b0;
        irq = 1'b1;
        for (int i = 0; i < 60; i++) begin
            step();
            k++;
            irq = 1'b0;
            if (wake_ack) break;
            prev_core = core_clk_en;
        end
        chk(k == exp_settle(s) + 3, "R7", $sformatf("wake latency src %0d", s), k, exp_settle(s) + 3);
        chk(prev_core == 1'b1, "R6", "clock released before ack", prev_core, 1);
        chk(mode_o == 2'd0, "R6", "mode at ack", mode_o, 0);
    endtask

    task automatic t_reset();
        chk(mode_o == 2'd0 && core_clk_en && main_pwr_on && main_rst_n, "R1",
            "run state after reset", {mode_o, core_clk_en, main_pwr_on, main_rst_n}, 5'b00111);
        chk(periph_clk_en == periph_en, "R1", "periph gates", periph_clk_en, periph_en);
        chk(!wake_ack && !dpd_flag, "R1", "ack and flag clear", {wake_ack, dpd_flag}, 0);
    endtask

    task automatic t_run_src();
        for (int s = 0; s < 4; s++) begin
            clk_src = 2'(s);
            step();
            chk(src_en == exp_mask(s), "R2", $sformatf("src_en for %0d", s), src_en, exp_mask(s));
        end
        clk_src = 2'd0;
    endtask

    task automatic t_sleep();
        periph_en = 4'b1010;
        step();
        pulse_wfi(2'b00);
        chk(mode_o == 2'd1 && !core_clk_en, "R3", "sleep entry", {mode_o, core_clk_en}, 3'b010);
        chk(periph_clk_en == 4'b1010 && ana_en == 3'b111, "R3", "sleep periph/analog",
            {periph_clk_en, ana_en}, 7'b1010111);
        repeat (3) step();
        chk(mode_o == 2'd1, "R4", "sleep held without wake", mode_o, 1);
        irq = 1'b1;
        step();
        irq = 1'b0;
        chk(mode_o == 2'd0 && core_clk_en && wake_ack, "R4", "irq wake",
            {mode_o, core_clk_en, wake_ack}, 4'b0011);
        step();
        chk(!wake_ack, "R4", "ack one cycle", wake_ack, 0);
        pulse_wfi(2'b11);
        chk(mode_o == 2'd1, "R3", "mode 11 is sleep", mode_o, 1);
        wake_pin = 1'b1;
        step();
        wake_pin = 1'b0;
        chk(mode_o == 2'd0 && wake_ack, "R4", "pin wake", {mode_o, wake_ack}, 3'b001);
        step();
        periph_en = 4'b1111;
    endtask

    task automatic t_pd_gating();
        clk_src = 2'd1; pd_keep = 3'b010; pd_osc_keep = 1'b0;
        step();
        pulse_wfi(2'b01);
        chk(mode_o == 2'd2 && !core_clk_en && periph_clk_en == 4'b0000, "R5",
            "pd clocks off", {mode_o, core_clk_en, periph_clk_en}, 7'b1000000);
        chk(ana_en == 3'b010 && src_en == 4'b0000, "R5", "pd analog/source",
            {ana_en, src_en}, 7'b0100000);
        pd_osc_keep = 1'b1;
        step();
        chk(src_en == 4'b0010, "R5", "pd source kept", src_en, 4'b0010);
        pd_osc_keep = 1'b0;
        pd_wake_measure(1);
        step();
    endtask

    task automatic t_pd_latency();
        for (int s = 0; s < 4; s++) begin
            if (s == 1) continue;
            clk_src = 2'(s);
            step();
            pulse_wfi(2'b01);
            pd_wake_measure(s);
            step();
        end
        clk_src = 2'd0;
    endtask

    task automatic t_pll_lock();
        int k = 0;
        bit early = 1'b0;
        clk_src = 2'd3; src_rdy = 4'b0111;
        step();
        pulse_wfi(2'b01);
        irq = 1'b1;
        step();
        irq = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (wake_ack || core_clk_en) early = 1'b1;
        end
        chk(!early && mode_o == 2'd2, "R6", "waits for pll lock", early, 0);
        chk(src_en == 4'b1100, "R6", "xtal and pll enabled", src_en, 4'b1100);
        src_rdy = 4'b1111;
        for (int i = 0; i < 60; i++) begin
            step();
            k++;
            if (wake_ack) break;
        end
        chk(k == 22, "R6", "ack after lock plus settle", k, 22);
        clk_src = 2'd0;
        step();
    endtask

    task automatic t_pending();
        int k = 0;
        clk_src = 2'd2;
        step();
        pulse_wfi(2'b01);
        irq = 1'b1;
        step();
        irq = 1'b0;
        pulse_wfi(2'b00);
        chk(mode_o == 2'd2, "R12", "request held during wake", mode_o, 2);
        for (int i = 0; i < 60; i++) begin
            step();
            k++;
            if (wake_ack) break;
        end
        chk(wake_ack && mode_o == 2'd0, "R12", "run reached", {wake_ack, mode_o}, 3'b100);
        step();
        chk(mode_o == 2'd1, "R12", "held request enters sleep", mode_o, 1);
        irq = 1'b1;
        step();
        irq = 1'b0;
        step();
        clk_src = 2'd0;
    endtask

    task automatic t_dpd();
        int k = 0;
        aon_write(2'd1, 8'hA5);
        aon_write(2'd2, 8'h5A);
        aon_addr = 2'd1;
        step();
        chk(aon_rdata == 8'hA5, "R11", "write in run", aon_rdata, 8'hA5);
        pwr_good = 1'b0;
        pulse_wfi(2'b10);
        chk(mode_o == 2'd3 && !main_pwr_on && !main_rst_n, "R8", "dpd power off",
            {mode_o, main_pwr_on, main_rst_n}, 4'b1100);
        chk(!core_clk_en && periph_clk_en == 0 && ana_en == 0 && src_en == 0, "R8",
            "dpd enables off", {core_clk_en, periph_clk_en, ana_en, src_en}, 0);
        chk(dpd_flag, "R10", "flag set on entry", dpd_flag, 1);
        aon_write(2'd1, 8'h3C);
        irq = 1'b1;
        repeat (3) step();
        irq = 1'b0;
        chk(!main_pwr_on && mode_o == 2'd3, "R8", "irq ignored", main_pwr_on, 0);
        dpd_flag_clr = 1'b1;
        step();
        dpd_flag_clr = 1'b0;
        chk(dpd_flag, "R10", "clear ignored while off", dpd_flag, 1);
        wake_pin = 1'b1;
        step();
        wake_pin = 1'b0;
        chk(main_pwr_on && !main_rst_n, "R9", "power up, reset held",
            {main_pwr_on, main_rst_n}, 2'b10);
        aon_write(2'd2, 8'hFF);
        repeat (4) step();
        chk(!main_rst_n && mode_o == 2'd3, "R9", "waits for power good",
            {main_rst_n, mode_o}, 3'b011);
        pwr_good = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step();
            k++;
            if (main_rst_n) break;
        end
        chk(k == 5, "R9", "reset hold length", k, 5);
        chk(mode_o == 2'd0 && core_clk_en && !wake_ack, "R9", "run after dpd, no ack",
            {mode_o, core_clk_en, wake_ack}, 4'b0010);
        aon_addr = 2'd1;
        step();
        chk(aon_rdata == 8'hA5, "R11", "word kept, dpd write dropped", aon_rdata, 8'hA5);
        aon_addr = 2'd2;
        step();
        chk(aon_rdata == 8'h5A, "R11", "write in reset dropped", aon_rdata, 8'h5A);
        chk(dpd_flag, "R10", "flag survives wake", dpd_flag, 1);
        dpd_flag_clr = 1'b1;
        step();
        dpd_flag_clr = 1'b0;
        chk(!dpd_flag, "R10", "flag cleared", dpd_flag, 0);
    endtask

    initial begin
        rst_n = 1'b0; wfi_req = 1'b0; mode_sel = 2'b00; clk_src = 2'd0;
        periph_en = 4'b1111; pd_keep = 3'b000; pd_osc_keep = 1'b0;
        irq = 1'b0; wake_pin = 1'b0; src_rdy = 4'b1111; pwr_good = 1'b1;
        aon_we = 1'b0; aon_addr = 2'd0; aon_wdata = 8'h00; dpd_flag_clr = 1'b0;
        repeat (5) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_run_src();
        t_sleep();
        t_pd_gating();
        t_pd_latency();
        t_pll_lock();
        t_pending();
        t_dpd();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule